// File: doc/BRIEF.md
# Two-Wire Bus Clock Generator

This block produces the serial clock line timing for a two-wire bus controller while that controller owns the bus as master. The host sets two values. One is an 8-bit divide value. The other is a 2-bit power-of-four scale select. The block counts system clocks to time a high half-period and a low half-period. Each half lasts `8 + divide * scale` system clocks, so an unobstructed bus period is `16 + 2 * divide * scale` clocks. It does not drive the pad itself. It asserts `scl_low` when the open-drain clock pin must be pulled low.

The control unit can keep the line low with `hold`, for example while it waits for software to service a pending event. The generator also watches the sampled line `scl_in`. After it releases the line, it starts timing the high half only once the line actually reads high, so any other device may stretch the clock. The block emits a one-cycle strobe at each falling and rising edge it creates. The bus sequencer uses these strobes to place data changes inside the low half and to sample data in the high half. When `master_active` is low, the generator releases the line and stays idle.

The scale select sits in the low bits of a status word. The upper bits of that word are read-only status supplied by the control unit.

Top module: `sclgen`

## Requirements
- R1: The divide register resets to 0x00. A pulse on `div_wr` loads all 8 bits of `wr_data`, and `div_rd` returns the stored value.
- R2: `stat_rd` is formed as follows: bits [7:3] equal `stat_code`, bit 2 is 0, and bits [1:0] are the scale select, which resets to 00. A `stat_wr` pulse updates only bits [1:0], from `wr_data[1:0]`.
- R3: The scale select decodes 00 to 1, 01 to 4, 10 to 16 and 11 to 64.
- R4: With the line unobstructed and `hold` low, the clock period is 16 + 2 × divide × scale system clocks. `scl_low` is asserted for exactly half of each period.
- R5: One cycle after `master_active` is sampled low, `scl_low` is 0. It stays 0 with no strobes for as long as `master_active` stays low.
- R6: While `hold` is high, `scl_low` remains asserted past the end of the low half. The line is released on the clock edge at which `hold` is first sampled low.
- R7: After a release, the high half is timed only from the first edge at which `scl_in` is sampled high. `scl_low` is asserted again half − 1 edges after that edge, where half = 8 + divide × scale.
- R8: `tick_fall` is a one-cycle pulse in the cycle in which `scl_low` becomes 1. `tick_rise` is a one-cycle pulse in the cycle after the edge that first samples `scl_in` high. The two strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divide register |
| stat_wr | input | 1 | Write strobe for the status word (only the scale select is written) |
| wr_data | input | 8 | Host write data |
| stat_code | input | 5 | Read-only status code from the control unit |
| div_rd | output | 8 | Divide register read value |
| stat_rd | output | 8 | Status word read value |
| master_active | input | 1 | High while the controller is bus master |
| hold | input | 1 | Keep the clock low (controller waiting on software) |
| scl_in | input | 1 | Synchronised level of the clock line |
| scl_low | output | 1 | Pull the clock line low when 1 |
| tick_fall | output | 1 | Strobe at each generated falling edge |
| tick_rise | output | 1 | Strobe when the released line is first seen high |

## Verification
The hardest situation to reach from the ports is a released line that another device still holds low. In that state the generator must neither count nor strobe until the line rises. The bench models the pin as a wired-AND of `scl_low` and an external pull-down. It raises the pull-down on the strobe that opens a low half and keeps it for many cycles. Only then does it let the line rise and time the edge count to the next fall. Stretching by `hold` is reached the same way, and both the release edge and the absence of strobes are checked.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;

  // Scale factor = 2^(step_log2 * sel); returned as a shift amount.
  function automatic int unsigned scale_shift(input int unsigned sel,
                                              input int unsigned step_log2);
    return sel * step_log2;
  endfunction

  // Width needed for the largest half period.
  function automatic int unsigned half_width(input int unsigned div_w,
                                             input int unsigned ps_w,
                                             input int unsigned step_log2);
    return div_w + scale_shift((1 << ps_w) - 1, step_log2) + 1;
  endfunction

endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PS_W   = 2,
  parameter int unsigned CODE_W = DIV_W - 1 - PS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic              stat_wr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic [CODE_W-1:0] stat_code,
  output logic [DIV_W-1:0]  div_q,
  output logic [PS_W-1:0]   sel_q,
  output logic [DIV_W-1:0]  stat_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      if (div_wr)  div_q <= wr_data;
      if (stat_wr) sel_q <= wr_data[PS_W-1:0];
    end
  end

  assign stat_word = {stat_code, 1'b0, sel_q};

  // R1: divide register only moves on its own strobe
  p_div_only_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(div_wr) |-> $stable(div_q));

  // R2: scale select only moves on a status write
  p_sel_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> $stable(sel_q));

endmodule

// File: rtl/sclgen_scale.sv
module sclgen_scale #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned PS_W      = 2,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned BASE_HALF = 8,
  parameter int unsigned HALF_W    = 15
) (
  input  logic [DIV_W-1:0]  div_q,
  input  logic [PS_W-1:0]   sel_q,
  output logic [HALF_W-1:0] half_len
);
  import sclgen_pkg::*;

  localparam int unsigned NSEL = 1 << PS_W;

  logic [HALF_W-1:0] factor_tbl [NSEL];
  logic [HALF_W-1:0] factor;

  for (genvar g = 0; g < NSEL; g++) begin : g_factor
    assign factor_tbl[g] = HALF_W'(1) << scale_shift(g, STEP_LOG2);
  end

  assign factor   = factor_tbl[sel_q];
  assign half_len = HALF_W'(BASE_HALF) + HALF_W'(div_q) * factor;

  // R3: every decoded scale is a single power of two
  always_comb begin
    p_factor_pow2_r3: assert ($onehot(factor));
  end

endmodule

// File: rtl/sclgen_timer.sv
module sclgen_timer #(
  parameter int unsigned HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_len,
  input  logic              master_active,
  input  logic              hold,
  input  logic              scl_in,
  output logic              scl_low,
  output logic              tick_fall,
  output logic              tick_rise
);
  import sclgen_pkg::*;

  phase_e            phase;
  logic [HALF_W-1:0] cnt;
  logic              high_done;
  logic              low_done;
  logic              line_seen_high;

  assign high_done      = (cnt >= half_len);
  assign low_done       = (cnt >= half_len) && !hold;
  assign line_seen_high = (phase == PH_WAIT) && scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      scl_low   <= 1'b0;
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
    end else begin
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
      if (!master_active) begin
        phase   <= PH_IDLE;
        cnt     <= '0;
        scl_low <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            phase   <= PH_WAIT;
            scl_low <= 1'b0;
          end
          PH_WAIT: begin
            if (line_seen_high) begin
              // the release cycle counts as the first high cycle
              phase     <= PH_HIGH;
              cnt       <= HALF_W'(2);
              tick_rise <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (high_done) begin
              phase     <= PH_LOW;
              cnt       <= HALF_W'(1);
              scl_low   <= 1'b1;
              tick_fall <= 1'b1;
            end else begin
              cnt <= cnt + HALF_W'(1);
            end
          end
          PH_LOW: begin
            if (low_done) begin
              phase   <= PH_WAIT;
              cnt     <= '0;
              scl_low <= 1'b0;
            end else if (cnt < half_len) begin
              cnt <= cnt + HALF_W'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R5: no drive once master ownership is gone
  p_release_when_slave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master_active) |-> !scl_low);

  // R6: a held low half keeps the line pulled down
  p_hold_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW && hold && master_active) |=> scl_low);

  // R7: high timing only starts on a line that reads high
  p_rise_needs_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> $past(scl_in));

  // R8: fall strobe marks the cycle the pull-down begins
  p_fall_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> (scl_low && !$past(scl_low)));

  // R8: strobes are exclusive
  p_ticks_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fall && tick_rise));

endmodule

// File: rtl/sclgen.sv
module sclgen #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned PS_W      = 2,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned BASE_HALF = 8,
  parameter int unsigned CODE_W    = DIV_W - 1 - PS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic              stat_wr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic [CODE_W-1:0] stat_code,
  output logic [DIV_W-1:0]  div_rd,
  output logic [DIV_W-1:0]  stat_rd,
  input  logic              master_active,
  input  logic              hold,
  input  logic              scl_in,
  output logic              scl_low,
  output logic              tick_fall,
  output logic              tick_rise
);
  import sclgen_pkg::*;

  localparam int unsigned HALF_W = half_width(DIV_W, PS_W, STEP_LOG2);

  logic [DIV_W-1:0]  div_q;
  logic [PS_W-1:0]   sel_q;
  logic [HALF_W-1:0] half_len;

  sclgen_regs #(
    .DIV_W (DIV_W),
    .PS_W  (PS_W),
    .CODE_W(CODE_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_wr   (div_wr),
    .stat_wr  (stat_wr),
    .wr_data  (wr_data),
    .stat_code(stat_code),
    .div_q    (div_q),
    .sel_q    (sel_q),
    .stat_word(stat_rd)
  );

  sclgen_scale #(
    .DIV_W    (DIV_W),
    .PS_W     (PS_W),
    .STEP_LOG2(STEP_LOG2),
    .BASE_HALF(BASE_HALF),
    .HALF_W   (HALF_W)
  ) u_scale (
    .div_q   (div_q),
    .sel_q   (sel_q),
    .half_len(half_len)
  );

  sclgen_timer #(
    .HALF_W(HALF_W)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_len     (half_len),
    .master_active(master_active),
    .hold         (hold),
    .scl_in       (scl_in),
    .scl_low      (scl_low),
    .tick_fall    (tick_fall),
    .tick_rise    (tick_rise)
  );

  assign div_rd = div_q;

endmodule

// File: tb/test_sclgen.sv
module test_sclgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic       stat_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] stat_code = 5'b10101;
  logic [7:0] div_rd;
  logic [7:0] stat_rd;
  logic       master_active = 1'b0;
  logic       hold = 1'b0;
  logic       ext_pull = 1'b0;
  logic       scl_in;
  logic       scl_low;
  logic       tick_fall;
  logic       tick_rise;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  assign scl_in = !scl_low && !ext_pull;

  always #2 clk = ~clk;

  sclgen i_sclgen (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .stat_wr(stat_wr),
    .wr_data(wr_data), .stat_code(stat_code), .div_rd(div_rd),
    .stat_rd(stat_rd), .master_active(master_active), .hold(hold),
    .scl_in(scl_in), .scl_low(scl_low), .tick_fall(tick_fall),
    .tick_rise(tick_rise)
  );

  localparam int NV = 7;
  localparam logic [7:0]  V_DIV [NV] = '{8'd0, 8'd1, 8'd3, 8'd2, 8'd1, 8'd5, 8'd10};
  localparam logic [1:0]  V_SEL [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd3};
  localparam int          V_PER [NV] = '{16, 18, 40, 80, 144, 56, 1296};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic write_div(input logic [7:0] v);
    @(negedge clk); div_wr = 1'b1; wr_data = v;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic write_stat(input logic [7:0] v);
    @(negedge clk); stat_wr = 1'b1; wr_data = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!tick_fall);
  endtask

  // period and low-time between two falls
  task automatic measure(output int per, output int low);
    wait_fall();
    per = 0; low = 0;
    do begin
      if (scl_low) low++;
      per++;
      @(negedge clk);
    end while (!tick_fall);
  endtask

  initial begin
    int per, low, half, k;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2 reset state
    check("R1 reset div", div_rd, 0);
    check("R2 reset stat", stat_rd, {stat_code, 3'b000});
    check("R5 idle after reset", scl_low, 0);

    write_div(8'hA5);
    check("R1 readback", div_rd, 8'hA5);
    write_stat(8'hFF);
    check("R2 only select written", stat_rd, 8'hAB);
    write_stat(8'h02);
    check("R2 select 10", stat_rd, 8'hAA);

    master_active = 1'b1;
    for (int i = 0; i < NV; i++) begin
      write_div(V_DIV[i]);
      write_stat({6'd0, V_SEL[i]});
      wait_fall();
      measure(per, low);
      check($sformatf("R4 R3 period vec%0d", i), per, V_PER[i]);
      check($sformatf("R4 low half vec%0d", i), low, V_PER[i] / 2);
    end

    // R6 hold stretch, half = 8 + 2*4 = 16
    write_div(8'd2); write_stat(8'd1);
    half = 16;
    wait_fall(); wait_fall();
    hold = 1'b1;
    seen = 0;
    repeat (3 * half) begin
      @(negedge clk);
      if (tick_rise || tick_fall) seen = 1;
    end
    check("R6 still low under hold", scl_low, 1);
    check("R6 no strobes under hold", seen, 0);
    hold = 1'b0;
    @(negedge clk);
    check("R6 release after hold drop", scl_low, 0);

    // R7 external stretch
    wait_fall();
    ext_pull = 1'b1;
    seen = 0;
    repeat (3 * half) begin
      @(negedge clk);
      if (tick_rise || tick_fall) seen = 1;
    end
    check("R7 released while pulled", scl_low, 0);
    check("R7 no strobe while pulled", seen, 0);
    ext_pull = 1'b0;
    @(negedge clk);
    check("R8 rise strobe", tick_rise, 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick_fall);
    check("R7 edges to fall", k, half - 1);
    check("R8 fall with drive", scl_low, 1);

    // R5 leave master mode
    wait_fall();
    @(negedge clk);
    master_active = 1'b0;
    @(negedge clk);
    check("R5 released", scl_low, 0);
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (tick_rise || tick_fall || scl_low) seen = 1;
    end
    check("R5 quiet in slave", seen, 0);

    finish_run();
  end

endmodule